// File: doc/BRIEF.md
# Programming image checksum accumulator

This block builds the 16-bit verification checksum of a device memory image as the words stream past. A producer pulses `start`, then presents 14-bit words one per cycle. Each word carries a kind tag: a program-memory word, the first configuration word, the second configuration word, or one of four user-identification words chosen by a 2-bit index. A pulse on `finish` asks for the result. One cycle later `done` is high for a single cycle and `checksum` carries the value.

The two configuration words are ANDed with fixed masks of their implemented bits and always enter the sum. The rest of the sum depends on the code-protect bit. This is bit 7 of configuration word 1, and it is active low. When protection is off, the block adds every program word that was presented. When protection is on, the block ignores the program words. It adds a 16-bit value instead, packed from the low nibble of each user-identification word. The protection bit is read when `finish` arrives, so the words may come in any order.

Top module: `ckm_checksum_top`

## Requirements
- R1: After reset, `done` is 0 and `checksum` is 0x0000.
- R2: Only bits 13:0 of `in_word` are used. Bits 15:14 have no effect on any result.
- R3: All additions are modulo 2^16 and carries out of bit 15 are dropped. A blank image of 0x2000 program words, each 0x3FFF, with both configuration words at 0x3FFF and protection off, gives 0x5EF2.
- R4: Configuration word 1 is ANDed with 0x3EFF and configuration word 2 with 0x3FF3 before they are added.
- R5: When bit 7 of the held configuration word 1 is 1 (protection off), the result is the masked configuration sum plus the sum of every program word presented since `start`.
- R6: When bit 7 of the held configuration word 1 is 0 (protection on), the result is the masked configuration sum plus the packed user-identification value. Program words have no effect. For example, configuration words 0x3F7F and 0x3FFF with user IDs 6, 7, 1, 2 give 0xE584.
- R7: `in_kind` encoding: 0 = program word, 1 = configuration word 1, 2 = configuration word 2, 3 = user-identification word selected by `in_uid_sel`. In the packed value, user ID 0 supplies bits 15:12, ID 1 bits 11:8, ID 2 bits 7:4 and ID 3 bits 3:0, each from bits 3:0 of its word.
- R8: `start` clears the program sum. It also returns both configuration words and all user IDs to the erased value 0x3FFF. With no words presented, the result is therefore 0x7EF2.
- R9: `done` goes high exactly one cycle after a `finish` cycle and stays high for one cycle only. `checksum` changes only on that cycle and holds its value otherwise.
- R10: A later configuration or user-identification word of the same kind and index replaces the earlier one.
- R11: A word presented while `in_valid` is 0 has no effect. A word in the same cycle as `start` is dropped. A word in the same cycle as `finish` is not part of that result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Clears the accumulation state |
| in_valid | input | 1 | Word strobe |
| in_kind | input | 2 | Word kind tag |
| in_uid_sel | input | 2 | User-identification word index |
| in_word | input | 16 | Input word; bits 13:0 are used |
| finish | input | 1 | Requests the result |
| done | output | 1 | One-cycle result strobe |
| checksum | output | 16 | Checksum result |

## Verification
A blank image and a protected image with known checksums anchor the masks, the 2^16 wrap and the nibble placement. An empty image after `start` shows the erased defaults. Random images choose the protection bit at random, put noise in the upper input bits, add idle cycles and rewrite configuration and user-identification words. A bench model predicts each result, which separates the protected path from the unprotected path and catches a wrong nibble order. A pair of protected runs that share their configuration and user IDs but differ in their program words must give the same value. This shows that program words are ignored when protection is on.

// File: rtl/ckm_pkg.sv
// Shared constants and types of the checksum accumulator.
// Assumes 14-bit memory words and a 16-bit checksum.
package ckm_pkg;
    typedef enum logic [1:0] {
        KIND_PROG = 2'd0,
        KIND_CFG1 = 2'd1,
        KIND_CFG2 = 2'd2,
        KIND_UID  = 2'd3
    } word_kind_t;

    localparam logic [15:0] CFG1_MASK  = 16'h3EFF;
    localparam logic [15:0] CFG2_MASK  = 16'h3FF3;
    localparam int          CP_BIT     = 7;
endpackage

// File: rtl/ckm_word_gate.sv
// Decodes a tagged input word into per-kind strobes and truncates it
// to the memory word width. Assumes IN_W >= WORD_W + 1.
module ckm_word_gate #(
    parameter int IN_W   = 16,
    parameter int WORD_W = 14
) (
    input  logic              valid,
    input  logic              clear,
    input  logic [1:0]        kind,
    input  logic [IN_W-1:0]   word,
    output logic [WORD_W-1:0] word_lo,
    output logic              hit_prog,
    output logic              hit_cfg1,
    output logic              hit_cfg2,
    output logic              hit_uid
);
    import ckm_pkg::*;

    logic take;
    logic unused_hi;

    assign word_lo   = word[WORD_W-1:0];
    assign unused_hi = ^word[IN_W-1:WORD_W];

    // Accept a word only when strobed and not overridden by a clear.
    assign take = valid && !clear;

    // Route the strobe to the decoded kind.
    always_comb begin
        hit_prog = 1'b0;
        hit_cfg1 = 1'b0;
        hit_cfg2 = 1'b0;
        hit_uid  = 1'b0;
        if (take) begin
            case (word_kind_t'(kind))
                KIND_PROG: hit_prog = 1'b1;
                KIND_CFG1: hit_cfg1 = 1'b1;
                KIND_CFG2: hit_cfg2 = 1'b1;
                default:   hit_uid  = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/ckm_accum.sv
// Modulo 2^SUM_W running sum of zero-extended words.
// Assumes SUM_W >= WORD_W; clear has priority over add.
module ckm_accum #(
    parameter int SUM_W  = 16,
    parameter int WORD_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              add_en,
    input  logic [WORD_W-1:0] addend,
    output logic [SUM_W-1:0]  sum
);
    localparam int PAD_W = SUM_W - WORD_W;

    logic [SUM_W-1:0] addend_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            assign addend_ext = {{PAD_W{1'b0}}, addend};
        end else begin : g_nopad
            assign addend_ext = addend;
        end
    endgenerate

    // Keep the wrapping sum; carries beyond SUM_W drop naturally.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sum <= '0;
        end else if (add_en) begin
            sum <= sum + addend_ext;
        end
    end
endmodule

// File: rtl/ckm_uid_pack.sv
// Holds one nibble per user-identification word and presents them
// packed, slot 0 in the most significant nibble. Clears to all ones.
module ckm_uid_pack #(
    parameter int UID_CNT = 4,
    parameter int NIB_W   = 4,
    localparam int SEL_W  = (UID_CNT > 1) ? $clog2(UID_CNT) : 1,
    localparam int PACK_W = UID_CNT * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [NIB_W-1:0]  nib,
    output logic [PACK_W-1:0] packed_val
);
    generate
        for (genvar i = 0; i < UID_CNT; i++) begin : g_slot
            localparam int LSB = (UID_CNT - 1 - i) * NIB_W;
            // Capture the nibble addressed to this slot.
            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    packed_val[LSB +: NIB_W] <= '1;
                end else if (wr_en && (sel == SEL_W'(i))) begin
                    packed_val[LSB +: NIB_W] <= nib;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/ckm_checksum_top.sv
// Checksum accumulator top. Collects program, configuration and user-ID
// words; on finish forms the masked configuration sum plus either the
// program sum or the packed user-ID value, selected by the code-protect bit.
// Assumes finish is not issued in the same cycle as start.
module ckm_checksum_top #(
    parameter int IN_W    = 16,
    parameter int WORD_W  = 14,
    parameter int SUM_W   = 16,
    parameter int UID_CNT = 4,
    parameter int NIB_W   = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         in_valid,
    input  logic [1:0]                   in_kind,
    input  logic [$clog2(UID_CNT)-1:0]   in_uid_sel,
    input  logic [IN_W-1:0]              in_word,
    input  logic                         finish,
    output logic                         done,
    output logic [SUM_W-1:0]             checksum
);
    import ckm_pkg::*;

    localparam int PACK_W = UID_CNT * NIB_W;
    localparam int PAD_W  = SUM_W - WORD_W;
    localparam logic [WORD_W-1:0] MASK1 = WORD_W'(CFG1_MASK);
    localparam logic [WORD_W-1:0] MASK2 = WORD_W'(CFG2_MASK);

    logic [WORD_W-1:0] word_lo;
    logic              hit_prog, hit_cfg1, hit_cfg2, hit_uid;
    logic [SUM_W-1:0]  prog_sum;
    logic [PACK_W-1:0] uid_packed;
    logic [WORD_W-1:0] cfg1_q, cfg2_q;
    logic [SUM_W-1:0]  cfg_sum, tail_val, result;
    logic              protect_on;

    ckm_word_gate #(.IN_W(IN_W), .WORD_W(WORD_W)) gate_i (
        .valid    (in_valid),
        .clear    (start),
        .kind     (in_kind),
        .word     (in_word),
        .word_lo  (word_lo),
        .hit_prog (hit_prog),
        .hit_cfg1 (hit_cfg1),
        .hit_cfg2 (hit_cfg2),
        .hit_uid  (hit_uid)
    );

    ckm_accum #(.SUM_W(SUM_W), .WORD_W(WORD_W)) accum_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start),
        .add_en (hit_prog),
        .addend (word_lo),
        .sum    (prog_sum)
    );

    ckm_uid_pack #(.UID_CNT(UID_CNT), .NIB_W(NIB_W)) uid_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (start),
        .wr_en      (hit_uid),
        .sel        (in_uid_sel),
        .nib        (word_lo[NIB_W-1:0]),
        .packed_val (uid_packed)
    );

    // Hold the latest configuration words; erased value after clear.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            cfg1_q <= '1;
            cfg2_q <= '1;
        end else begin
            if (hit_cfg1) cfg1_q <= word_lo;
            if (hit_cfg2) cfg2_q <= word_lo;
        end
    end

    assign protect_on = !cfg1_q[CP_BIT];

    // Combine masked configuration words with the protection-selected term.
    always_comb begin
        cfg_sum  = {{PAD_W{1'b0}}, cfg1_q & MASK1} + {{PAD_W{1'b0}}, cfg2_q & MASK2};
        tail_val = protect_on ? SUM_W'(uid_packed) : prog_sum;
        result   = cfg_sum + tail_val;
    end

    // Present the result with a one-cycle strobe after finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            checksum <= '0;
        end else begin
            done <= finish;
            if (finish) checksum <= result;
        end
    end
endmodule

// File: rtl/ckm_checksum_chk.sv
// Protocol and state checks for the checksum accumulator, bound to the top.
module ckm_checksum_chk #(
    parameter int WORD_W  = 14,
    parameter int SUM_W   = 16,
    parameter int UID_CNT = 4,
    parameter int NIB_W   = 4,
    parameter int IN_W    = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       start,
    input logic                       in_valid,
    input logic [1:0]                 in_kind,
    input logic [$clog2(UID_CNT)-1:0] in_uid_sel,
    input logic [IN_W-1:0]            in_word,
    input logic                       finish,
    input logic                       done,
    input logic [SUM_W-1:0]           checksum,
    input logic [SUM_W-1:0]           prog_sum,
    input logic [UID_CNT*NIB_W-1:0]   uid_packed,
    input logic [WORD_W-1:0]          cfg1_q
);
    localparam int PACK_W = UID_CNT * NIB_W;

    p_done_after_finish_r9: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> done);

    p_no_spurious_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> !done);

    p_hold_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> $stable(checksum));

    p_start_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (prog_sum == '0 && cfg1_q == '1 && uid_packed == '1));

    p_prog_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !start && in_kind == 2'd0) |=>
        prog_sum == $past(prog_sum) + SUM_W'($past(in_word[WORD_W-1:0])));

    p_uid_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !start && in_kind == 2'd3 && in_uid_sel == '0) |=>
        uid_packed[PACK_W-1 -: NIB_W] == $past(in_word[NIB_W-1:0]));
endmodule

bind ckm_checksum_top ckm_checksum_chk #(
    .WORD_W(WORD_W), .SUM_W(SUM_W), .UID_CNT(UID_CNT), .NIB_W(NIB_W), .IN_W(IN_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .in_valid   (in_valid),
    .in_kind    (in_kind),
    .in_uid_sel (in_uid_sel),
    .in_word    (in_word),
    .finish     (finish),
    .done       (done),
    .checksum   (checksum),
    .prog_sum   (prog_sum),
    .uid_packed (uid_packed),
    .cfg1_q     (cfg1_q)
);

// File: tb/ckm_checksum_top_tb_top.sv
// Self-checking bench for the checksum accumulator.
module ckm_checksum_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_kind = 2'd0;
    logic [1:0]  in_uid_sel = 2'd0;
    logic [15:0] in_word = 16'h0;
    logic        finish = 1'b0;
    logic        done;
    logic [15:0] checksum;

    int checks = 0;
    int fails  = 0;

    // Bench model state
    logic [15:0] m_prog;
    logic [13:0] m_cfg1, m_cfg2;
    logic [3:0]  m_uid [4];

    always #5 clk = ~clk;

    ckm_checksum_top dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_kind(in_kind), .in_uid_sel(in_uid_sel), .in_word(in_word),
        .finish(finish), .done(done), .checksum(checksum)
    );

    function automatic logic [15:0] expect_sum(logic [13:0] c1, logic [13:0] c2,
                                               logic [15:0] psum, logic [15:0] packed_id);
        logic [15:0] base;
        base = {2'b00, c1 & 14'h3EFF} + {2'b00, c2 & 14'h3FF3};
        return c1[7] ? base + psum : base + packed_id;
    endfunction

    function automatic logic [15:0] model_result();
        return expect_sum(m_cfg1, m_cfg2, m_prog, {m_uid[0], m_uid[1], m_uid[2], m_uid[3]});
    endfunction

    task automatic check16(string tag, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic model_clear();
        m_prog = 16'h0;
        m_cfg1 = 14'h3FFF;
        m_cfg2 = 14'h3FFF;
        for (int i = 0; i < 4; i++) m_uid[i] = 4'hF;
    endtask

    task automatic do_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        model_clear();
    endtask

    // Drive one word for one cycle and update the model when strobed.
    task automatic send(logic v, logic [1:0] k, logic [1:0] sel, logic [15:0] w);
        @(negedge clk);
        in_valid = v; in_kind = k; in_uid_sel = sel; in_word = w;
        if (v) begin
            case (k)
                2'd0: m_prog = m_prog + {2'b00, w[13:0]};
                2'd1: m_cfg1 = w[13:0];
                2'd2: m_cfg2 = w[13:0];
                default: m_uid[sel] = w[3:0];
            endcase
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Pulse finish and check the strobe, value and hold (R9).
    task automatic finish_check(string tag, logic [15:0] exp);
        logic [15:0] held;
        @(negedge clk);
        finish = 1'b1;
        @(negedge clk);
        finish = 1'b0;
        check16({tag, " done R9"}, {15'h0, done}, 16'h1);
        check16(tag, checksum, exp);
        held = checksum;
        @(negedge clk);
        check16({tag, " done drop R9"}, {15'h0, done}, 16'h0);
        check16({tag, " hold R9"}, checksum, held);
    endtask

    task automatic send_cfg_uid(logic [15:0] c1, logic [15:0] c2,
                                logic [3:0] u0, logic [3:0] u1, logic [3:0] u2, logic [3:0] u3);
        send(1'b1, 2'd1, 2'd0, c1);
        send(1'b1, 2'd2, 2'd0, c2);
        send(1'b1, 2'd3, 2'd0, {12'h0, u0});
        send(1'b1, 2'd3, 2'd1, {12'h0, u1});
        send(1'b1, 2'd3, 2'd2, {12'h0, u2});
        send(1'b1, 2'd3, 2'd3, {12'h0, u3});
    endtask

    // Watchdog
    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] r;
        logic [15:0] first_val;
        r = $urandom(32'h00C0FFEE);
        model_clear();
        repeat (3) @(negedge clk);
        check16("reset done R1", {15'h0, done}, 16'h0);
        check16("reset checksum R1", checksum, 16'h0);
        rst_n = 1'b1;

        // R8: erased defaults with nothing presented
        do_start();
        finish_check("empty image R8", 16'h7EF2);

        // R3, R4, R5: blank unprotected image
        do_start();
        for (int a = 0; a < 8192; a++) begin
            @(negedge clk);
            in_valid = 1'b1; in_kind = 2'd0; in_word = 16'h3FFF;
        end
        @(negedge clk);
        in_valid = 1'b0;
        send(1'b1, 2'd1, 2'd0, 16'h3FFF);
        send(1'b1, 2'd2, 2'd0, 16'h3FFF);
        finish_check("blank image R3 R5", 16'h5EF2);

        // R6, R7: protected example, program words present but ignored
        do_start();
        send(1'b1, 2'd0, 2'd0, 16'h1234);
        send(1'b1, 2'd0, 2'd0, 16'h0ABC);
        send_cfg_uid(16'h3F7F, 16'h3FFF, 4'h6, 4'h7, 4'h1, 4'h2);
        finish_check("protected example R6 R7", 16'hE584);

        // R8: start after a populated run clears everything
        do_start();
        finish_check("cleared by start R8", 16'h7EF2);

        // R2, R4: upper bits ignored, masks applied
        do_start();
        send(1'b1, 2'd0, 2'd0, 16'hC001);
        send(1'b1, 2'd1, 2'd0, 16'hC0FF);
        send(1'b1, 2'd2, 2'd0, 16'h800C);
        finish_check("upper bits R2 R4", expect_sum(14'h00FF, 14'h000C, 16'h0001, 16'hFFFF));

        // R11, R10: idle junk, overwritten IDs, word alongside start
        do_start();
        send(1'b0, 2'd0, 2'd0, 16'h3FFF);
        send(1'b0, 2'd1, 2'd0, 16'h0000);
        send_cfg_uid(16'h0000, 16'h3FFF, 4'h1, 4'h2, 4'h3, 4'h4);
        send(1'b1, 2'd3, 2'd2, 16'h000A);
        send(1'b1, 2'd2, 2'd0, 16'h1111);
        finish_check("idle and overwrite R10 R11", model_result());
        @(negedge clk);
        start = 1'b1; in_valid = 1'b1; in_kind = 2'd0; in_word = 16'h0005;
        @(negedge clk);
        start = 1'b0; in_valid = 1'b0;
        model_clear();
        finish_check("word with start dropped R11", 16'h7EF2);

        // R6: same protected setup, different program words, equal results
        do_start();
        send(1'b1, 2'd0, 2'd0, 16'h0101);
        send_cfg_uid(16'h3F00, 16'h2222, 4'h9, 4'hC, 4'h0, 4'h5);
        finish_check("protected A R6", model_result());
        first_val = checksum;
        do_start();
        send(1'b1, 2'd0, 2'd0, 16'h3E3E);
        send(1'b1, 2'd0, 2'd0, 16'h0777);
        send_cfg_uid(16'h3F00, 16'h2222, 4'h9, 4'hC, 4'h0, 4'h5);
        finish_check("protected B R6", first_val);

        // Random images against the model (R2 R5 R6 R7 R10 R11)
        for (int run = 0; run < 24; run++) begin
            int n;
            do_start();
            n = 50 + int'($urandom_range(0, 250));
            for (int k = 0; k < n; k++) begin
                r = 16'($urandom());
                send(($urandom_range(0, 7) != 0), 2'($urandom_range(0, 3)),
                     2'($urandom_range(0, 3)), r);
            end
            r = 16'($urandom());
            r[7] = run[0];
            send(1'b1, 2'd1, 2'd0, r);
            finish_check("random image R5 R6 R7", model_result());
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule